// File: doc/BRIEF.md
# Overlapped Fetch, Address-Decode and Operand Pipeline Sequencer

This block sequences single-cycle instructions through three overlapping stages. While one instruction is being fetched from program memory, the previous one is decoded by the address unit and reads its operand from data RAM. The operand of the instruction before that is handed to the datapath with a load strobe. In steady state three instructions are in flight and one finishes in every instruction cycle. Each instruction cycle has two phases, a high phase followed by a low phase. Every bus update happens on the phase boundary assigned to it.

The block runs from a clock at twice the instruction rate. A toggle flop derives the phase, and the block exports it so that the attached memories can time their accesses. Program memory and data RAM sit outside the block as synchronous arrays. Each one returns its word at the mid-cycle edge that follows the address. A copy of the program address is delayed by one phase and presented as the external memory address.

Top module: `fdo_pipe`

## Requirements
- R1: `phase_hi` is low while reset is held. It goes high at the first clock edge after reset is released and toggles on every edge after that. One instruction cycle is one high phase followed by one low phase.
- R2: At the start of the high phase of instruction cycle k (k = 0 for the first cycle after reset), `pab` equals k modulo 2^AW. It does not change at the mid-cycle edge.
- R3: `xab` takes the value of `pab` one phase later. During the low phase of cycle k it equals k modulo 2^AW, and it does not change at the cycle boundary.
- R4: The word present on `pdb` at the end of cycle k is the instruction fetched from address k. During cycle k+1 it is shown on `dec_instr` with `dec_valid` high.
- R5: An instruction whose bit IW-1 is 1 requests an operand. During its decode cycle `dre` is high and `dab` equals its bits DAW-1..0. For an instruction with bit IW-1 equal to 0, `dre` stays low.
- R6: In the cycle after the decode cycle of an operand-requesting instruction, `ld` is high and `opnd` holds the word that `ddb` carried at the end of the decode cycle. For any other instruction, `ld` is low in that cycle.
- R7: During cycle k+2, `dp_instr` equals instruction k and `dp_valid` is high. Instructions k, k+1 and k+2 therefore occupy the three stages together.
- R8: A synchronous reset sets the program counter so that the next fetch is from address 0. It empties all stages (`dec_valid`, `dp_valid`, `dre` and `ld` low, with `pab` and `xab` at 0). After release, no stage reports valid and no strobe rises until an instruction has reached that stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the instruction rate |
| rst | input | 1 | Synchronous active-high reset |
| phase_hi | output | 1 | High during the first phase of each instruction cycle |
| pab | output | AW | Program address bus |
| xab | output | AW | External program address, one phase behind `pab` |
| pdb | input | IW | Program data bus (instruction word) |
| dab | output | DAW | Data RAM address |
| dre | output | 1 | Data RAM read request |
| ddb | input | DW | Data RAM read data |
| dec_instr | output | IW | Instruction in the decode stage |
| dec_valid | output | 1 | Decode stage holds an instruction |
| dp_instr | output | IW | Instruction in the datapath stage |
| dp_valid | output | 1 | Datapath stage holds an instruction |
| opnd | output | DW | Operand delivered to the datapath |
| ld | output | 1 | Datapath operand load strobe |

## Verification
The bench builds the block with IW=12, AW=6, DAW=5 and DW=16. The 64-word program space and the 32-word data RAM stay small, so a run of 70 instructions carries the program counter past its top and back through address 0. The narrow operand address means that random programs hit both end addresses of the data RAM. A second program alternates requesting and non-requesting words, and it asserts reset while the pipeline is full, so the flushing of stages and strobes is checked in the middle of a run as well as at start-up.

// File: rtl/fdo_pkg.sv
package fdo_pkg;
  // Phase of the current instruction cycle; HI comes first.
  typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} phase_e;
endpackage

// File: rtl/fdo_phase.sv
module fdo_phase
  import fdo_pkg::*;
(
  input  logic   clk2x,
  input  logic   rst,
  output phase_e ph
);
  // Reset parks in LO so the first edge after release opens a HI phase.
  always_ff @(posedge clk2x) begin
    if (rst) ph <= PH_LO;
    else     ph <= (ph == PH_HI) ? PH_LO : PH_HI;
  end

  AST_PHASE_TOGGLE: assert property (@(posedge clk2x) disable iff (rst)
    1'b1 |=> (ph != $past(ph))); // R1
endmodule

// File: rtl/fdo_fetch.sv
module fdo_fetch
  import fdo_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk2x,
  input  logic          rst,
  input  phase_e        ph,
  output logic [AW-1:0] pab,
  output logic [AW-1:0] xab,
  output logic          fv
);
  logic [AW-1:0] pc;

  // Cycle boundary (LO -> HI): PC drives the bus and advances.
  // Mid-cycle (HI -> LO): the external address catches up.
  always_ff @(posedge clk2x) begin
    if (rst) begin
      pc  <= '0;
      pab <= '0;
      xab <= '0;
      fv  <= 1'b0;
    end else if (ph == PH_LO) begin
      pab <= pc;
      pc  <= pc + 1'b1;
      fv  <= 1'b1;
    end else begin
      xab <= pab;
    end
  end

  AST_PAB_STEP: assert property (@(posedge clk2x) disable iff (rst)
    (ph == PH_LO && fv) |=> (pab == AW'($past(pab) + 1'b1))); // R2
  AST_PAB_MID_STABLE: assert property (@(posedge clk2x) disable iff (rst)
    (ph == PH_HI) |=> $stable(pab)); // R2
  AST_XAB_BND_STABLE: assert property (@(posedge clk2x) disable iff (rst)
    (ph == PH_LO) |=> $stable(xab)); // R3
endmodule

// File: rtl/fdo_adec.sv
module fdo_adec
  import fdo_pkg::*;
#(
  parameter int IW  = 16,
  parameter int DAW = 8
) (
  input  logic           clk2x,
  input  logic           rst,
  input  phase_e         ph,
  input  logic           fv,
  input  logic [IW-1:0]  pdb,
  output logic [IW-1:0]  ir,
  output logic           dv,
  output logic [DAW-1:0] dab,
  output logic           dre
);
  localparam int REQ_BIT = IW - 1;

  // At the cycle boundary the fetched word moves into decode, and the
  // RAM address plus the read request go out for the mid-cycle read.
  always_ff @(posedge clk2x) begin
    if (rst) begin
      ir  <= '0;
      dv  <= 1'b0;
      dab <= '0;
      dre <= 1'b0;
    end else if (ph == PH_LO) begin
      ir  <= pdb;
      dv  <= fv;
      dab <= pdb[DAW-1:0];
      dre <= fv & pdb[REQ_BIT];
    end
  end

  AST_DAB_MID_STABLE: assert property (@(posedge clk2x) disable iff (rst)
    (ph == PH_HI) |=> ($stable(dab) && $stable(dre))); // R5
endmodule

// File: rtl/fdo_opnd.sv
module fdo_opnd
  import fdo_pkg::*;
#(
  parameter int IW = 16,
  parameter int DW = 16
) (
  input  logic          clk2x,
  input  logic          rst,
  input  phase_e        ph,
  input  logic [IW-1:0] ir,
  input  logic          dv,
  input  logic          dre,
  input  logic [DW-1:0] ddb,
  output logic [IW-1:0] dp_instr,
  output logic          dp_valid,
  output logic [DW-1:0] opnd,
  output logic          ld
);
  always_ff @(posedge clk2x) begin
    if (rst) begin
      dp_instr <= '0;
      dp_valid <= 1'b0;
      opnd     <= '0;
      ld       <= 1'b0;
    end else if (ph == PH_LO) begin
      dp_instr <= ir;
      dp_valid <= dv;
      ld       <= dre;
      if (dre) opnd <= ddb;
    end
  end

  AST_LD_FULL_CYCLE: assert property (@(posedge clk2x) disable iff (rst)
    $rose(ld) |=> ld); // R6
  AST_OPND_MID_STABLE: assert property (@(posedge clk2x) disable iff (rst)
    (ph == PH_HI) |=> ($stable(opnd) && $stable(ld) && $stable(dp_instr))); // R7
endmodule

// File: rtl/fdo_pipe.sv
module fdo_pipe
  import fdo_pkg::*;
#(
  parameter int IW  = 16,
  parameter int AW  = 10,
  parameter int DAW = 8,
  parameter int DW  = 16
) (
  input  logic           clk2x,
  input  logic           rst,
  output logic           phase_hi,
  output logic [AW-1:0]  pab,
  output logic [AW-1:0]  xab,
  input  logic [IW-1:0]  pdb,
  output logic [DAW-1:0] dab,
  output logic           dre,
  input  logic [DW-1:0]  ddb,
  output logic [IW-1:0]  dec_instr,
  output logic           dec_valid,
  output logic [IW-1:0]  dp_instr,
  output logic           dp_valid,
  output logic [DW-1:0]  opnd,
  output logic           ld
);
  phase_e ph;
  logic   fv;

  fdo_phase u_phase (
    .clk2x (clk2x),
    .rst   (rst),
    .ph    (ph)
  );

  fdo_fetch #(.AW(AW)) u_fetch (
    .clk2x (clk2x),
    .rst   (rst),
    .ph    (ph),
    .pab   (pab),
    .xab   (xab),
    .fv    (fv)
  );

  fdo_adec #(.IW(IW), .DAW(DAW)) u_adec (
    .clk2x (clk2x),
    .rst   (rst),
    .ph    (ph),
    .fv    (fv),
    .pdb   (pdb),
    .ir    (dec_instr),
    .dv    (dec_valid),
    .dab   (dab),
    .dre   (dre)
  );

  fdo_opnd #(.IW(IW), .DW(DW)) u_opnd (
    .clk2x    (clk2x),
    .rst      (rst),
    .ph       (ph),
    .ir       (dec_instr),
    .dv       (dec_valid),
    .dre      (dre),
    .ddb      (ddb),
    .dp_instr (dp_instr),
    .dp_valid (dp_valid),
    .opnd     (opnd),
    .ld       (ld)
  );

  assign phase_hi = (ph == PH_HI);

  AST_REQ_THEN_LOAD: assert property (@(posedge clk2x) disable iff (rst)
    (!phase_hi && dre) |=> ld); // R6
  AST_NOREQ_NO_LOAD: assert property (@(posedge clk2x) disable iff (rst)
    (!phase_hi && dec_valid && !dre) |=> !ld); // R6
  AST_RST_EMPTY: assert property (@(posedge clk2x)
    rst |=> (!ld && !dre && !dec_valid && !dp_valid && pab == '0)); // R8
endmodule

// File: tb/sim_fdo_pipe.sv
module sim_fdo_pipe;
  localparam int IW  = 12;
  localparam int AW  = 6;
  localparam int DAW = 5;
  localparam int DW  = 16;
  localparam int NINS = 70;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           phase_hi;
  logic [AW-1:0]  pab, xab;
  logic [IW-1:0]  pdb = '0;
  logic [DAW-1:0] dab;
  logic           dre;
  logic [DW-1:0]  ddb = '0;
  logic [IW-1:0]  dec_instr, dp_instr;
  logic           dec_valid, dp_valid, ld;
  logic [DW-1:0]  opnd;

  int checks = 0;
  int errors = 0;
  int ncnt   = 0;
  bit done   = 1'b0;

  logic [IW-1:0] pmem [2**AW];
  logic [DW-1:0] dmem [2**DAW];

  int            q_pab [$];
  int            q_xab [$];
  logic [IW-1:0] q_dec [$];
  logic [IW-1:0] q_dp  [$];

  always #2 clk = ~clk; // 250 MHz

  fdo_pipe #(.IW(IW), .AW(AW), .DAW(DAW), .DW(DW)) u0 (
    .clk2x (clk), .rst (rst), .phase_hi (phase_hi),
    .pab (pab), .xab (xab), .pdb (pdb), .dab (dab), .dre (dre), .ddb (ddb),
    .dec_instr (dec_instr), .dec_valid (dec_valid),
    .dp_instr (dp_instr), .dp_valid (dp_valid), .opnd (opnd), .ld (ld)
  );

  // Synchronous memory models: read at the mid-cycle edge (leaving HI).
  always @(posedge clk) begin
    if (phase_hi) begin
      pdb <= pmem[pab];
      if (dre) ddb <= dmem[dab];
    end
  end

  // Edges since reset release.
  always @(posedge clk) ncnt <= rst ? 0 : ncnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops expected items as each stage presents them.
  always @(negedge clk) begin
    if (!rst && ncnt > 0) begin
      automatic int n = ncnt;
      chk(phase_hi == n[0], "R1 phase", 32'(phase_hi), 32'(n[0]));
      if (n[0]) begin
        if (q_pab.size() > 0) begin
          automatic int e = q_pab.pop_front();
          chk(int'(pab) == e, "R2 pab", 32'(pab), 32'(e));
        end
        if (n == 1) chk(!dec_valid && !dre, "R8 decode empty", 32'({dec_valid, dre}), 0);
        if (n <= 3) chk(!dp_valid && !ld, "R8 datapath empty", 32'({dp_valid, ld}), 0);
        if (n >= 3 && q_dec.size() > 0) begin
          automatic logic [IW-1:0] w = q_dec.pop_front();
          chk(dec_valid && dec_instr == w, "R4 dec_instr", 32'(dec_instr), 32'(w));
          chk(dre == w[IW-1], "R5 dre", 32'(dre), 32'(w[IW-1]));
          if (w[IW-1]) chk(dab == w[DAW-1:0], "R5 dab", 32'(dab), 32'(w[DAW-1:0]));
        end
        if (n >= 5 && q_dp.size() > 0) begin
          automatic logic [IW-1:0] w = q_dp.pop_front();
          chk(dp_valid && dp_instr == w, "R7 dp_instr", 32'(dp_instr), 32'(w));
          chk(ld == w[IW-1], "R6 ld", 32'(ld), 32'(w[IW-1]));
          if (w[IW-1])
            chk(opnd == dmem[w[DAW-1:0]], "R6 opnd", 32'(opnd), 32'(dmem[w[DAW-1:0]]));
        end
      end else if (q_xab.size() > 0) begin
        automatic int e = q_xab.pop_front();
        chk(int'(xab) == e, "R3 xab", 32'(xab), 32'(e));
      end
    end
  end

  // Driver: load a program, push the expected items, run it through.
  task automatic run_prog(input int mode);
    @(negedge clk); #1 rst = 1'b1;
    for (int i = 0; i < 2**AW; i++) begin
      if (mode == 0) pmem[i] = IW'($urandom);
      else           pmem[i] = {i[0], IW'(i * 7)}[IW-1:0] | (i[0] ? IW'(1) << (IW-1) : '0);
    end
    if (mode == 1) begin
      pmem[1] = {1'b1, {(IW-1){1'b0}}};          // operand address 0
      pmem[3] = {1'b1, {(IW-1){1'b1}}};          // operand address all ones
    end
    for (int k = 0; k < NINS; k++) begin
      q_pab.push_back(k % (2**AW));
      q_xab.push_back(k % (2**AW));
      q_dec.push_back(pmem[k % (2**AW)]);
      q_dp.push_back(pmem[k % (2**AW)]);
    end
    repeat (4) @(negedge clk);
    chk(!phase_hi, "R8 reset phase", 32'(phase_hi), 0);
    chk(pab == '0 && xab == '0, "R8 reset pab/xab", 32'({pab, xab}), 0);
    chk(!dre && !ld, "R8 reset strobes", 32'({dre, ld}), 0);
    chk(!dec_valid && !dp_valid, "R8 reset valids", 32'({dec_valid, dp_valid}), 0);
    #1 rst = 1'b0;
    while (q_pab.size() + q_xab.size() + q_dec.size() + q_dp.size() > 0)
      @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2**DAW; i++) dmem[i] = DW'(i * 16'h1357) ^ DW'(16'hA5C3);
    for (int i = 0; i < 2**AW; i++) pmem[i] = '0;
    run_prog(0);
    run_prog(1);   // reset asserted while the pipeline is full
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule